// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers of a 32-bit processor core. The core has seven operating modes, and some of them keep private copies of certain registers. A caller names an architectural register from 0 to 15 and supplies the current mode. The block then finds the physical register that the name refers to in that mode and reads or writes it there. Two read ports and one write port all use the current mode.

Architectural register 15 is the program counter. It has no storage in this block. Any read of it returns the value on an external PC input, and writes to it are dropped. The fast-interrupt mode has private copies of registers 8 to 14. The normal-interrupt, supervisor, abort and undefined modes each keep private copies of only the stack pointer (13) and the link register (14). User and system modes share a single set.

A third read port takes its own mode input. It can read a register from any named bank whatever the current mode is. The return path from an exception uses it. Reads are combinational, and a write in the same cycle to the same physical register is forwarded to the read. In total there are 30 stored registers, plus the program counter.

Top module: `mode_banked_regfile`

## Requirements
- R1: When `rst` is high at a rising clock edge, every stored register becomes zero. After that edge, every read of registers 0 to 14 in every mode returns 0.
- R2: A read of register 15 on any read port returns `pc_in`. A write to register 15 has no effect on any stored register.
- R3: Registers 0 to 7 are a single physical set shared by all modes.
- R4: Fast-interrupt mode (mode code 5'h11) has private registers 8 to 14. Writes to them in that mode leave the registers 8 to 14 of every other mode unchanged, and the reverse also holds.
- R5: Normal-interrupt (5'h12), supervisor (5'h13), abort (5'h17) and undefined (5'h1B) modes each have private registers 13 and 14. In these modes, registers 8 to 12 are the user-mode registers.
- R6: User mode (5'h10) and system mode (5'h1F) use the same physical registers 0 to 14.
- R7: A mode code not listed in R4 to R6 accesses the user bank.
- R8: Reads are combinational. If `wr_en` is high in the same cycle and the write maps to the same physical register, the read returns `wr_data`. The write itself takes effect at the rising edge.
- R9: The `xm_*` port reads register `xm_idx` from the bank of `xm_mode`, independently of `cur_mode`.
- R10: Read ports A and B address registers independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cur_mode | input | 5 | Current operating mode code |
| pc_in | input | 32 | Program counter value returned for register 15 |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| xm_mode | input | 5 | Mode whose bank the explicit-mode port reads |
| xm_idx | input | 4 | Explicit-mode port register number |
| xm_data | output | 32 | Explicit-mode port read data |

## Verification
The bench fills the user bank and then reads the same register numbers from every other mode. This finds a design that banks too much or too little. For example, a mapping that gave the two-register modes their own register 12 would return zero where the user value is expected. Each of the four two-register modes gets a distinct stack pointer value, so a slip in the bank index, where two modes alias one slot, shows up as a wrong value on readback. A write to register 15 is followed by reads of register 14 and register 0, which catches decoding that lets 15 fall into a stored slot. Forwarding is tested with the write and the read in the same cycle: a design without the bypass returns the old value. An invalid mode code is read back against the user data, which catches a decode that leaves it unbanked or assigns it to another bank.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_ABT = 5'h17;
    localparam logic [4:0] MODE_UND = 5'h1B;
    localparam logic [4:0] MODE_SYS = 5'h1F;

    localparam int ARCH_N    = 16;
    localparam int SHARED_N  = 15;
    localparam int FIQ_N     = 7;
    localparam int DUAL_N    = 2;
    localparam int DUAL_BANKS = 4;
    localparam int PHYS_N    = SHARED_N + FIQ_N + DUAL_N * DUAL_BANKS;
    localparam int PIDX_W    = $clog2(PHYS_N);
    localparam int FIQ_BASE  = SHARED_N;
    localparam int DUAL_BASE = FIQ_BASE + FIQ_N;

    typedef enum logic [2:0] {
        BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND
    } bank_e;

    typedef struct packed {
        logic              valid;
        logic [PIDX_W-1:0] idx;
    } phys_ref_t;

    function automatic bank_e mode_bank(input logic [4:0] mode);
        case (mode)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_USR;
        endcase
    endfunction

    function automatic logic [PIDX_W-1:0] dual_base(input bank_e bk);
        case (bk)
            BK_IRQ:  return PIDX_W'(DUAL_BASE);
            BK_SVC:  return PIDX_W'(DUAL_BASE + DUAL_N);
            BK_ABT:  return PIDX_W'(DUAL_BASE + 2 * DUAL_N);
            default: return PIDX_W'(DUAL_BASE + 3 * DUAL_N);
        endcase
    endfunction

    function automatic phys_ref_t phys_of(input logic [4:0] mode, input logic [3:0] arch);
        phys_ref_t r;
        bank_e     bk;
        bk      = mode_bank(mode);
        r.valid = (arch != 4'd15);
        r.idx   = PIDX_W'(arch);
        if (bk == BK_FIQ && arch >= 4'd8 && arch != 4'd15)
            r.idx = PIDX_W'(arch) + PIDX_W'(FIQ_BASE - 8);
        else if (bk != BK_USR && bk != BK_FIQ && (arch == 4'd13 || arch == 4'd14))
            r.idx = dual_base(bk) + PIDX_W'(arch == 4'd14);
        return r;
    endfunction

endpackage

// File: rtl/mbr_phys_map.sv
module mbr_phys_map
    import mbr_pkg::*;
(
    input  logic [4:0] mode,
    input  logic [3:0] arch,
    output phys_ref_t  pref
);
    always_comb pref = phys_of(mode, arch);
endmodule

// File: rtl/mbr_storage.sv
module mbr_storage
    import mbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_N   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  phys_ref_t                    wr_ref,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [RD_N-1:0][PIDX_W-1:0]  rd_idx,
    output logic [RD_N-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] regs [PHYS_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_N; i++) regs[i] <= '0;
        end else if (wr_en && wr_ref.valid) begin
            regs[wr_ref.idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        always_comb rd_data[p] = regs[rd_idx[p]];
    end
endmodule

// File: rtl/mbr_read_port.sv
module mbr_read_port
    import mbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  phys_ref_t          rd_ref,
    input  logic [DATA_W-1:0]  stored,
    input  logic               wr_en,
    input  phys_ref_t          wr_ref,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  pc_in,
    output logic [DATA_W-1:0]  rd_data
);
    always_comb begin
        if (!rd_ref.valid)
            rd_data = pc_in;
        else if (wr_en && wr_ref.valid && wr_ref.idx == rd_ref.idx)
            rd_data = wr_data;
        else
            rd_data = stored;
    end
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import mbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        cur_mode,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [4:0]        xm_mode,
    input  logic [3:0]        xm_idx,
    output logic [DATA_W-1:0] xm_data
);
    localparam int RD_N  = 3;
    localparam int MAP_N = RD_N + 1;

    logic [MAP_N-1:0][4:0]          map_mode;
    logic [MAP_N-1:0][3:0]          map_arch;
    phys_ref_t                      map_ref [MAP_N];
    logic [RD_N-1:0][PIDX_W-1:0]    st_idx;
    logic [RD_N-1:0][DATA_W-1:0]    st_data;
    logic [RD_N-1:0][DATA_W-1:0]    port_out;

    // slots: 0 = port A, 1 = port B, 2 = explicit-mode port, 3 = write
    always_comb begin
        map_mode[0] = cur_mode; map_arch[0] = rd_a_idx;
        map_mode[1] = cur_mode; map_arch[1] = rd_b_idx;
        map_mode[2] = xm_mode;  map_arch[2] = xm_idx;
        map_mode[3] = cur_mode; map_arch[3] = wr_idx;
    end

    for (genvar m = 0; m < MAP_N; m++) begin : g_map
        mbr_phys_map u_map (
            .mode (map_mode[m]),
            .arch (map_arch[m]),
            .pref (map_ref[m])
        );
    end

    for (genvar p = 0; p < RD_N; p++) begin : g_port
        always_comb st_idx[p] = map_ref[p].idx;
        mbr_read_port #(.DATA_W(DATA_W)) u_port (
            .rd_ref  (map_ref[p]),
            .stored  (st_data[p]),
            .wr_en   (wr_en),
            .wr_ref  (map_ref[RD_N]),
            .wr_data (wr_data),
            .pc_in   (pc_in),
            .rd_data (port_out[p])
        );
    end

    mbr_storage #(.DATA_W(DATA_W), .RD_N(RD_N)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ref  (map_ref[RD_N]),
        .wr_data (wr_data),
        .rd_idx  (st_idx),
        .rd_data (st_data)
    );

    assign rd_a_data = port_out[0];
    assign rd_b_data = port_out[1];
    assign xm_data   = port_out[2];
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        cur_mode,
    input logic [DATA_W-1:0] pc_in,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [4:0]        xm_mode,
    input logic [3:0]        xm_idx,
    input logic [DATA_W-1:0] xm_data
);
    assert_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en && rd_a_idx != 4'd15) |-> rd_a_data == '0);

    assert_pc_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 4'd15) |-> rd_b_data == pc_in);

    assert_low_shared_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_a_idx < 4'd8 && xm_idx == rd_a_idx) |-> xm_data == rd_a_data);

    assert_written_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && $past(wr_idx) != 4'd15 && !wr_en
         && rd_a_idx == $past(wr_idx) && cur_mode == $past(cur_mode))
        |-> rd_a_data == $past(wr_data));

    assert_same_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && xm_mode == cur_mode && xm_idx == rd_b_idx) |-> xm_data == rd_b_data);
endmodule

bind mode_banked_regfile mbr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cur_mode(cur_mode), .pc_in(pc_in),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .xm_mode(xm_mode), .xm_idx(xm_idx), .xm_data(xm_data)
);

// File: tb/mode_banked_regfile_tb.sv
module mode_banked_regfile_tb;
    localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                           ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F, BAD = 5'h05;

    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  cur_mode = USR;
    logic [31:0] pc_in = '0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, xm_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, xm_data, wr_data = '0;
    logic        wr_en = 0;
    logic [4:0]  xm_mode = USR;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    mode_banked_regfile u_dut (
        .clk(clk), .rst(rst), .cur_mode(cur_mode), .pc_in(pc_in),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .xm_mode(xm_mode), .xm_idx(xm_idx), .xm_data(xm_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        cur_mode = m; wr_idx = i; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_a(input logic [4:0] m, input logic [3:0] i, output logic [31:0] d);
        cur_mode = m; rd_a_idx = i; #1; d = rd_a_data;
    endtask

    task automatic rd_x(input logic [4:0] m, input logic [3:0] i, output logic [31:0] d);
        xm_mode = m; xm_idx = i; #1; d = xm_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        logic [4:0] ms [7] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
        for (int m = 0; m < 7; m++)
            for (int i = 0; i < 15; i++) begin
                rd_x(ms[m], 4'(i), v); chk("R1 reset zero", v, 32'h0);
            end
    endtask

    task automatic t_user_fill;
        logic [31:0] v;
        for (int i = 0; i < 15; i++) wr(USR, 4'(i), 32'h1000 + i);
        for (int i = 0; i < 15; i++) begin
            rd_a(FIQ, 4'(i), v);
            chk(i < 8 ? "R3 low shared in fiq" : "R4 fiq private unwritten", v, i < 8 ? 32'h1000 + i : 32'h0);
            rd_a(SVC, 4'(i), v);
            chk(i < 13 ? "R5 svc sees user r0-r12" : "R5 svc private unwritten", v, i < 13 ? 32'h1000 + i : 32'h0);
            rd_a(SYS, 4'(i), v); chk("R6 system equals user", v, 32'h1000 + i);
            rd_a(BAD, 4'(i), v); chk("R7 bad code uses user bank", v, 32'h1000 + i);
        end
    endtask

    task automatic t_fiq;
        logic [31:0] v;
        for (int i = 8; i < 15; i++) wr(FIQ, 4'(i), 32'hF000 + i);
        for (int i = 8; i < 15; i++) begin
            rd_a(FIQ, 4'(i), v); chk("R4 fiq private readback", v, 32'hF000 + i);
            rd_a(USR, 4'(i), v); chk("R4 user unchanged by fiq", v, 32'h1000 + i);
        end
        cur_mode = USR; rd_a_idx = 4'd10; rd_x(FIQ, 4'd10, v);
        chk("R9 explicit fiq read from user", v, 32'hF00A);
        rd_x(IRQ, 4'd10, v); chk("R9 explicit irq r10 is user", v, 32'h100A);
    endtask

    task automatic t_dual;
        logic [31:0] v;
        logic [4:0] ms [4] = '{IRQ, SVC, ABT, UND};
        for (int m = 0; m < 4; m++) begin
            wr(ms[m], 4'd13, 32'hA000 + m * 16);
            wr(ms[m], 4'd14, 32'hB000 + m * 16);
        end
        wr(SVC, 4'd9, 32'h9999);
        for (int m = 0; m < 4; m++) begin
            rd_a(ms[m], 4'd13, v); chk("R5 private sp", v, 32'hA000 + m * 16);
            rd_x(ms[m], 4'd14, v); chk("R9 explicit private lr", v, 32'hB000 + m * 16);
        end
        rd_a(USR, 4'd13, v); chk("R5 user sp unchanged", v, 32'h100D);
        rd_a(FIQ, 4'd13, v); chk("R4 fiq sp unchanged", v, 32'hF00D);
        rd_a(USR, 4'd9, v); chk("R5 svc r9 is user r9", v, 32'h9999);
    endtask

    task automatic t_pc;
        logic [31:0] v;
        @(negedge clk);
        pc_in = 32'hCAFE_0040; cur_mode = IRQ; rd_a_idx = 4'd15; rd_b_idx = 4'd15;
        xm_mode = FIQ; xm_idx = 4'd15; #1;
        chk("R2 pc on port A", rd_a_data, 32'hCAFE_0040);
        chk("R2 pc on port B", rd_b_data, 32'hCAFE_0040);
        chk("R2 pc on explicit port", xm_data, 32'hCAFE_0040);
        wr(USR, 4'd15, 32'hDEAD_BEEF);
        rd_a(USR, 4'd14, v); chk("R2 r15 write leaves r14", v, 32'h100E);
        rd_a(USR, 4'd0, v);  chk("R2 r15 write leaves r0", v, 32'h1000);
        rd_a(USR, 4'd15, v); chk("R2 r15 still pc", v, 32'hCAFE_0040);
    endtask

    task automatic t_forward;
        @(negedge clk);
        cur_mode = ABT; wr_idx = 4'd13; wr_data = 32'h5555_0001; wr_en = 1;
        rd_a_idx = 4'd13; rd_b_idx = 4'd12; #1;
        chk("R8 same-cycle forward", rd_a_data, 32'h5555_0001);
        chk("R8 no forward other reg", rd_b_data, 32'h100C);
        @(negedge clk);
        wr_en = 0; #1;
        chk("R8 write landed", rd_a_data, 32'h5555_0001);
        cur_mode = UND; #1;
        chk("R8 no forward across banks", rd_a_data, 32'hA030);
    endtask

    task automatic t_dual_port;
        @(negedge clk);
        cur_mode = FIQ; rd_a_idx = 4'd3; rd_b_idx = 4'd11; #1;
        chk("R10 port A", rd_a_data, 32'h1003);
        chk("R10 port B", rd_b_data, 32'hF00B);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                t_reset();
                t_user_fill();
                t_fiq();
                t_dual();
                t_pc();
                t_forward();
                t_dual_port();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule